// File: doc/BRIEF.md
# Two-Way Mailbox with Doorbell Interrupts and MSI Composition

This block holds one message slot in each direction between a local endpoint host and a remote root complex. The local host reaches its registers through a simple write/combinational-read bus. From there it places an outbound message, raises the outbound ready flag, sets the interrupt enables and programs a vector. The remote side has its own write/read port onto the same slots. It uses that port to fetch the outbound message, clear the outbound flag, deposit an inbound message and raise the inbound flag. It also programs an MSI enable, a multiple-message field and a base message-data word.

When the outbound flag goes from clear to set and both the remote MSI enable and the local outbound enable are on, the block emits a one-cycle MSI request. The request comes with a message-data word: the base word with its low N bits taken from the local vector, where N is the multiple-message field clamped to 5. The inbound flag drives a level interrupt to the local host whenever the inbound enable is set. Each flag is raised only by the sending side and cleared only by the receiving side. While a flag is up, the sender cannot overwrite that direction's data.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset both ready flags, both data slots, all enables, the vector, the multiple-message field and the base word read as zero, and `l_irq` and `msi_req` are low.
- R2: A local write to address 0 loads the outbound slot. A local write to address 1 with bit 0 set raises the outbound flag. The remote port then reads the slot at address 0 and the flag at bit 0 of address 1.
- R3: `msi_req` is high for exactly the one cycle after the clock edge at which the outbound flag goes 0 to 1. It goes high only if remote address 4 bit 0 (MSI enable) and local address 2 bit 0 (outbound enable) were both set at that edge.
- R4: Writing bit 0 of local address 1 again while the outbound flag is already set produces no further MSI request.
- R5: `msi_data` is the base word from remote address 5 with its low N bits replaced by the low N bits of the vector at local address 3. N is bits 3:1 of remote address 4; a value of 0 leaves the base unchanged and values above 5 act as 5.
- R6: Only a remote write of 1 to bit 0 of address 1 clears the outbound flag. Local writes to address 1 never clear it.
- R7: While the outbound flag is set, local writes to address 0 are ignored. Once it clears, they take effect again.
- R8: A remote write to address 2 loads the inbound slot. A remote write to address 3 with bit 0 set raises the inbound flag. The local port reads the slot at address 4 and the flag at bit 0 of address 5.
- R9: `l_irq` is high exactly while the inbound flag and the inbound enable (local address 2 bit 1) are both set.
- R10: Only a local write of 1 to bit 0 of address 5 clears the inbound flag. Remote writes to address 3 never clear it.
- R11: While the inbound flag is set, remote writes to address 2 are ignored. Once it clears, they take effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_wr_en | input | 1 | Local register write strobe |
| l_addr | input | 3 | Local register address |
| l_wdata | input | DATA_W | Local write data |
| l_rdata | output | DATA_W | Local read data (combinational on `l_addr`) |
| l_irq | output | 1 | Level interrupt to the local host |
| r_wr_en | input | 1 | Remote register write strobe |
| r_addr | input | 3 | Remote register address |
| r_wdata | input | DATA_W | Remote write data |
| r_rdata | output | DATA_W | Remote read data (combinational on `r_addr`) |
| msi_req | output | 1 | One-cycle MSI request |
| msi_data | output | MSI_DATA_W | Composed MSI message data, held after each request |

## Verification
The bench builds the block with its defaults: 32-bit slots, a 16-bit message-data word and an 8-bit vector. With an 8-bit vector, a multiple-message value of 7 still has vector bits beyond the fifth to draw on. A wrong clamp would pull those bits into `msi_data`, so that case shows it. A 16-bit base with distinct nibbles makes every replaced bit visible. Those widths also leave upper base bits that must pass through untouched.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W  = 3;
  localparam int MME_W   = 3;
  localparam int MME_CAP = 5;

  // local side register addresses
  localparam logic [ADDR_W-1:0] L_OUT_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] L_OUT_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] L_IRQ_EN   = 3'd2;
  localparam logic [ADDR_W-1:0] L_VECTOR   = 3'd3;
  localparam logic [ADDR_W-1:0] L_IN_DATA  = 3'd4;
  localparam logic [ADDR_W-1:0] L_IN_FLAG  = 3'd5;

  // remote side register addresses
  localparam logic [ADDR_W-1:0] R_OUT_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] R_OUT_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] R_IN_DATA  = 3'd2;
  localparam logic [ADDR_W-1:0] R_IN_FLAG  = 3'd3;
  localparam logic [ADDR_W-1:0] R_MSI_CTL  = 3'd4;
  localparam logic [ADDR_W-1:0] R_MSI_BASE = 3'd5;
endpackage

// File: rtl/mbox_slot.sv
// One direction of the mailbox: a data slot guarded by a ready flag.
module mbox_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_data_we,
  input  logic [DATA_W-1:0] snd_data,
  input  logic              snd_set,
  input  logic              rcv_clr,
  output logic              ready,
  output logic [DATA_W-1:0] data,
  output logic              set_evt
);
  // a set request only counts as an event when the flag is low
  assign set_evt = snd_set && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      data  <= '0;
    end else begin
      if (snd_data_we && !ready) data <= snd_data;
      if (set_evt)              ready <= 1'b1;
      else if (rcv_clr)         ready <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_msi.sv
// Registered MSI request pulse and message-data composition.
module mbox_msi #(
  parameter int MSI_DATA_W = 16,
  parameter int VEC_W      = 8,
  parameter int MME_W      = 3,
  parameter int MME_CAP    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig,
  input  logic                  msi_en,
  input  logic                  src_en,
  input  logic [MSI_DATA_W-1:0] base,
  input  logic [VEC_W-1:0]      vec,
  input  logic [MME_W-1:0]      mme,
  output logic                  msi_req,
  output logic [MSI_DATA_W-1:0] msi_data
);
  localparam int LOW_W = (MSI_DATA_W < VEC_W) ? MSI_DATA_W : VEC_W;

  function automatic logic [MSI_DATA_W-1:0] compose(
    input logic [MSI_DATA_W-1:0] b,
    input logic [VEC_W-1:0]      v,
    input logic [MME_W-1:0]      m
  );
    int n;
    logic [MSI_DATA_W-1:0] r;
    n = (int'(m) > MME_CAP) ? MME_CAP : int'(m);
    r = b;
    for (int i = 0; i < LOW_W; i++) begin
      if (i < n) r[i] = v[i];
    end
    return r;
  endfunction

  logic fire;
  assign fire = trig && msi_en && src_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_req  <= 1'b0;
      msi_data <= '0;
    end else begin
      msi_req <= fire;
      if (fire) msi_data <= compose(base, vec, mme);
    end
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MSI_DATA_W = 16,
  parameter int VEC_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  l_wr_en,
  input  logic [2:0]            l_addr,
  input  logic [DATA_W-1:0]     l_wdata,
  output logic [DATA_W-1:0]     l_rdata,
  output logic                  l_irq,
  input  logic                  r_wr_en,
  input  logic [2:0]            r_addr,
  input  logic [DATA_W-1:0]     r_wdata,
  output logic [DATA_W-1:0]     r_rdata,
  output logic                  msi_req,
  output logic [MSI_DATA_W-1:0] msi_data
);
  // named internal events and state, also used by the checker
  logic                  out_ready, in_ready;
  logic [DATA_W-1:0]     out_data, in_data;
  logic                  out_set_evt, in_set_evt;
  logic                  out_ie, in_ie, msi_en;
  logic [VEC_W-1:0]      vec;
  logic [MME_W-1:0]      mme;
  logic [MSI_DATA_W-1:0] msi_base;

  logic l_out_data_we, l_out_set, l_in_clr;
  logic r_in_data_we, r_in_set, r_out_clr;

  assign l_out_data_we = l_wr_en && (l_addr == L_OUT_DATA);
  assign l_out_set     = l_wr_en && (l_addr == L_OUT_FLAG) && l_wdata[0];
  assign l_in_clr      = l_wr_en && (l_addr == L_IN_FLAG)  && l_wdata[0];
  assign r_in_data_we  = r_wr_en && (r_addr == R_IN_DATA);
  assign r_in_set      = r_wr_en && (r_addr == R_IN_FLAG)  && r_wdata[0];
  assign r_out_clr     = r_wr_en && (r_addr == R_OUT_FLAG) && r_wdata[0];

  // outbound: local sends, remote clears
  mbox_slot #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .snd_data_we(l_out_data_we), .snd_data(l_wdata), .snd_set(l_out_set),
    .rcv_clr(r_out_clr),
    .ready(out_ready), .data(out_data), .set_evt(out_set_evt)
  );

  // inbound: remote sends, local clears
  mbox_slot #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .snd_data_we(r_in_data_we), .snd_data(r_wdata), .snd_set(r_in_set),
    .rcv_clr(l_in_clr),
    .ready(in_ready), .data(in_data), .set_evt(in_set_evt)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_ie   <= 1'b0;
      in_ie    <= 1'b0;
      vec      <= '0;
      msi_en   <= 1'b0;
      mme      <= '0;
      msi_base <= '0;
    end else begin
      if (l_wr_en && l_addr == L_IRQ_EN) begin
        out_ie <= l_wdata[0];
        in_ie  <= l_wdata[1];
      end
      if (l_wr_en && l_addr == L_VECTOR) vec <= l_wdata[VEC_W-1:0];
      if (r_wr_en && r_addr == R_MSI_CTL) begin
        msi_en <= r_wdata[0];
        mme    <= r_wdata[MME_W:1];
      end
      if (r_wr_en && r_addr == R_MSI_BASE) msi_base <= r_wdata[MSI_DATA_W-1:0];
    end
  end

  mbox_msi #(
    .MSI_DATA_W(MSI_DATA_W), .VEC_W(VEC_W), .MME_W(MME_W), .MME_CAP(MME_CAP)
  ) u_msi (
    .clk(clk), .rst_n(rst_n),
    .trig(out_set_evt), .msi_en(msi_en), .src_en(out_ie),
    .base(msi_base), .vec(vec), .mme(mme),
    .msi_req(msi_req), .msi_data(msi_data)
  );

  assign l_irq = in_ready && in_ie;

  always_comb begin
    l_rdata = '0;
    case (l_addr)
      L_OUT_DATA: l_rdata = out_data;
      L_OUT_FLAG: l_rdata = DATA_W'(out_ready);
      L_IRQ_EN:   l_rdata = DATA_W'({in_ie, out_ie});
      L_VECTOR:   l_rdata = DATA_W'(vec);
      L_IN_DATA:  l_rdata = in_data;
      L_IN_FLAG:  l_rdata = DATA_W'(in_ready);
      default:    l_rdata = '0;
    endcase
  end

  always_comb begin
    r_rdata = '0;
    case (r_addr)
      R_OUT_DATA: r_rdata = out_data;
      R_OUT_FLAG: r_rdata = DATA_W'(out_ready);
      R_IN_DATA:  r_rdata = in_data;
      R_IN_FLAG:  r_rdata = DATA_W'(in_ready);
      R_MSI_CTL:  r_rdata = DATA_W'({mme, msi_en});
      R_MSI_BASE: r_rdata = DATA_W'(msi_base);
      default:    r_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MSI_DATA_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  l_wr_en,
  input logic [2:0]            l_addr,
  input logic [DATA_W-1:0]     l_wdata,
  input logic                  r_wr_en,
  input logic [2:0]            r_addr,
  input logic [DATA_W-1:0]     r_wdata,
  input logic                  l_irq,
  input logic                  msi_req,
  input logic [MSI_DATA_W-1:0] msi_data,
  input logic                  out_ready,
  input logic                  in_ready,
  input logic [DATA_W-1:0]     out_data,
  input logic [DATA_W-1:0]     in_data,
  input logic                  msi_en,
  input logic                  out_ie,
  input logic [MSI_DATA_W-1:0] msi_base
);
  p_msi_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $rose(out_ready));

  p_msi_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(msi_en && out_ie));

  p_msi_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);

  p_msi_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> ((msi_data >> MME_CAP) == ($past(msi_base) >> MME_CAP)));

  p_out_clear_remote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_ready) |-> $past(r_wr_en && r_addr == R_OUT_FLAG && r_wdata[0]));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && $past(out_ready)) |-> $stable(out_data));

  p_in_set_remote_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(r_wr_en && r_addr == R_IN_FLAG && r_wdata[0]));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l_irq |-> in_ready);

  p_in_clear_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(l_wr_en && l_addr == L_IN_FLAG && l_wdata[0]));

  p_in_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(in_ready)) |-> $stable(in_data));
endmodule

bind mbox_doorbell mbox_doorbell_chk #(
  .DATA_W(DATA_W), .MSI_DATA_W(MSI_DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_wr_en(l_wr_en), .l_addr(l_addr), .l_wdata(l_wdata),
  .r_wr_en(r_wr_en), .r_addr(r_addr), .r_wdata(r_wdata),
  .l_irq(l_irq), .msi_req(msi_req), .msi_data(msi_data),
  .out_ready(out_ready), .in_ready(in_ready),
  .out_data(out_data), .in_data(in_data),
  .msi_en(msi_en), .out_ie(out_ie), .msi_base(msi_base)
);

// File: tb/tb_mbox_doorbell.sv
module tb_mbox_doorbell;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 32;
  localparam int MW  = 16;
  localparam int VW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          l_wr_en = 1'b0;
  logic [2:0]    l_addr = '0;
  logic [DW-1:0] l_wdata = '0;
  logic [DW-1:0] l_rdata;
  logic          l_irq;
  logic          r_wr_en = 1'b0;
  logic [2:0]    r_addr = '0;
  logic [DW-1:0] r_wdata = '0;
  logic [DW-1:0] r_rdata;
  logic          msi_req;
  logic [MW-1:0] msi_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [MW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_doorbell #(.DATA_W(DW), .MSI_DATA_W(MW), .VEC_W(VW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_wr_en(l_wr_en), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_irq(l_irq),
    .r_wr_en(r_wr_en), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .msi_req(msi_req), .msi_data(msi_data)
  );

  // reference composition by masking
  function automatic logic [MW-1:0] ref_msi(logic [MW-1:0] base, logic [VW-1:0] v, int m);
    int n = (m > 5) ? 5 : m;
    logic [MW-1:0] mask = MW'((1 << n) - 1);
    return (base & ~mask) | (MW'(v) & mask);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic lwr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    l_wr_en = 1'b1; l_addr = a; l_wdata = d;
    @(negedge clk);
    l_wr_en = 1'b0;
  endtask

  task automatic rwr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    r_wr_en = 1'b1; r_addr = a; r_wdata = d;
    @(negedge clk);
    r_wr_en = 1'b0;
  endtask

  task automatic lrd(string req, logic [2:0] a, logic [DW-1:0] exp);
    l_addr = a; #1;
    check(req, l_rdata, exp);
  endtask

  task automatic rrd(string req, logic [2:0] a, logic [DW-1:0] exp);
    r_addr = a; #1;
    check(req, r_rdata, exp);
  endtask

  // driver: raise outbound flag, pushing the expected MSI when one is due
  task automatic send_out(bit expect_msi, logic [MW-1:0] exp_data);
    if (expect_msi) exp_q.push_back(exp_data);
    lwr(3'd1, 32'h1);
  endtask

  // monitor: every pulse must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && msi_req) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R4: got unexpected msi_req data %h expected no pulse", msi_data);
      end else begin
        logic [MW-1:0] e;
        e = exp_q.pop_front();
        if (msi_data !== e) begin
          errors++;
          $display("FAIL R5: got msi_data %h expected %h", msi_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) lrd("R1", 3'(a), '0);
    for (int a = 0; a < 6; a++) rrd("R1", 3'(a), '0);
    check("R1 irq", DW'(l_irq), '0);
    check("R1 msi", DW'(msi_req), '0);

    // configure: msi_en=1, mme=3, base=ABCD; out_ie=1, vector=5A
    rwr(3'd4, {28'd0, 3'd3, 1'b1});
    rwr(3'd5, 32'h0000_ABCD);
    lwr(3'd2, 32'h1);
    lwr(3'd3, 32'h5A);
    lwr(3'd0, 32'h1122_3344);

    // R2, R3, R5: first doorbell, mme=3
    send_out(1'b1, ref_msi(16'hABCD, 8'h5A, 3));
    check("R5 mme3 model", DW'(ref_msi(16'hABCD, 8'h5A, 3)), 32'h0000_ABCA);
    rrd("R2 out data", 3'd0, 32'h1122_3344);
    rrd("R2 out flag", 3'd1, 32'h1);
    lrd("R2 local flag", 3'd1, 32'h1);

    // R4: set again while set, no pulse
    send_out(1'b0, '0);
    // R7: overwrite ignored while set
    lwr(3'd0, 32'hDEAD_BEEF);
    rrd("R7 hold", 3'd0, 32'h1122_3344);
    // R6: local writes do not clear
    lwr(3'd1, 32'h0);
    rrd("R6 local no clear", 3'd1, 32'h1);
    // R6: remote writing 0 does not clear, writing 1 does
    rwr(3'd1, 32'h0);
    rrd("R6 remote zero", 3'd1, 32'h1);
    rwr(3'd1, 32'h1);
    rrd("R6 remote clear", 3'd1, 32'h0);
    // R7: write accepted after clear
    lwr(3'd0, 32'h0000_0055);
    rrd("R7 accept", 3'd0, 32'h0000_0055);

    // R5: mme=0 leaves base unchanged
    rwr(3'd4, {28'd0, 3'd0, 1'b1});
    send_out(1'b1, ref_msi(16'hABCD, 8'h5A, 0));
    rwr(3'd1, 32'h1);
    // R5: mme=7 clamps to 5
    rwr(3'd4, {28'd0, 3'd7, 1'b1});
    send_out(1'b1, ref_msi(16'hABCD, 8'h5A, 7));
    check("R5 clamp model", DW'(ref_msi(16'hABCD, 8'h5A, 7)), 32'h0000_ABDA);
    rwr(3'd1, 32'h1);

    // R3: MSI enable off -> no pulse
    rwr(3'd4, {28'd0, 3'd2, 1'b0});
    send_out(1'b0, '0);
    rrd("R3 flag still set", 3'd1, 32'h1);
    rwr(3'd1, 32'h1);
    // R3: outbound enable off -> no pulse
    rwr(3'd4, {28'd0, 3'd2, 1'b1});
    lwr(3'd2, 32'h0);
    send_out(1'b0, '0);
    rwr(3'd1, 32'h1);
    // R3: both on again with mme=2
    lwr(3'd2, 32'h1);
    lwr(3'd3, 32'hF3);
    send_out(1'b1, ref_msi(16'hABCD, 8'hF3, 2));
    rwr(3'd1, 32'h1);

    // R8 / R9: inbound with enable off
    lwr(3'd2, 32'h1);
    rwr(3'd2, 32'h0000_CAFE);
    rwr(3'd3, 32'h1);
    lrd("R8 in data", 3'd4, 32'h0000_CAFE);
    lrd("R8 in flag", 3'd5, 32'h1);
    check("R9 irq gated", DW'(l_irq), '0);
    lwr(3'd2, 32'h3);
    check("R9 irq level", DW'(l_irq), 32'h1);
    // R11: inbound overwrite ignored
    rwr(3'd2, 32'h0000_BEEF);
    lrd("R11 hold", 3'd4, 32'h0000_CAFE);
    // R10: remote cannot clear
    rwr(3'd3, 32'h0);
    lrd("R10 remote no clear", 3'd5, 32'h1);
    check("R9 irq held", DW'(l_irq), 32'h1);
    // R10: local W1C
    lwr(3'd5, 32'h1);
    lrd("R10 local clear", 3'd5, 32'h0);
    check("R9 irq drop", DW'(l_irq), '0);
    // R11: accepted after clear
    rwr(3'd2, 32'h0000_0777);
    lrd("R11 accept", 3'd4, 32'h0000_0777);

    repeat (3) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: got %0d missing msi pulses expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule